// File: doc/BRIEF.md
# ALU Instruction Group Framer

The framer sits at the front of an ALU clause pipeline. It takes 64-bit clause words, one per cycle under a valid/ready handshake, and finds the instruction group boundaries in that stream. A group is one to five ALU operations followed by up to two literal words. The last operation of the group carries a terminator bit, which ends the operation portion. The framer then works out how many literal words follow by scanning the source-select fields of every operation for literal references.

When a group is complete, the framer presents it on one output beat. The beat carries the operations placed on lanes x, y, z, w and t in arrival order, the literal words split into 32-bit halves, per-lane and per-half presence masks, the operation and literal counts, and an error flag. The beat stays unchanged until it is accepted. A stream in which five operations arrive without a terminator is reported as malformed, and framing restarts on the following word. Opcode decoding, operand fetch and execution are left to later stages.

Top module: `alu_group_framer`

## Requirements
- R1: After a synchronous active-high reset, out_valid is 0, in_ready is 1, out_op_count is 0, and the next accepted word is taken as the first operation of a group.
- R2: An operation word with bit 63 set ends the operation portion. Operations go to lanes 0..4 (x, y, z, w, t) in arrival order, lane i at out_ops[64*i +: 64]. out_op_count is the number of operations, and out_lane_valid has its low out_op_count bits set.
- R3: Each operation has three 2-bit source selects at bits [1:0], [3:2] and [5:4]. A select equal to 2'b11 references the literal component held in bits [9:8], [11:10] or [13:12] respectively. Select values 0, 1 and 2 reference no literal, whatever their component field holds.
- R4: Literal words are counted over all operations of the group. The count is 0 with no reference, 1 when the highest referenced component is 0 or 1, and 2 when it is 2 or 3. That many words after the terminating operation are taken as literals, and out_lit_count reports the count.
- R5: Literal word k supplies half 2k in its bits [31:0] and half 2k+1 in its bits [63:32]. Half j appears at out_lits[32*j +: 32], and out_half_valid has its low 2*out_lit_count bits set.
- R6: out_valid rises in the cycle after the final word of a group is accepted. It and every output field then hold steady until out_ready is seen high.
- R7: in_ready is 0 while out_valid is 1. After the hand-off, out_valid drops and the next accepted word starts a new group. No input word is lost or taken twice under backpressure.
- R8: If a fifth operation arrives without bit 63 set, a beat is presented with out_error=1, out_op_count=5 and out_lit_count=0. The next word starts a fresh group.
- R9: Lanes and literal halves not filled by the current group read as zero.
- R10: Reset asserted in the middle of a group discards the partial group, and no beat is produced for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Framer can take a word |
| in_word | input | 64 | Clause word (operation or literal) |
| out_valid | output | 1 | Complete group presented |
| out_ready | input | 1 | Consumer accepts the group |
| out_ops | output | 320 | Five 64-bit operation lanes |
| out_lane_valid | output | 5 | Lanes holding an operation |
| out_lits | output | 128 | Four 32-bit literal halves |
| out_half_valid | output | 4 | Literal halves present |
| out_op_count | output | 3 | Operations in the group (1-5) |
| out_lit_count | output | 2 | Literal words in the group (0-2) |
| out_error | output | 1 | Group was malformed |

## Verification
The bench sweeps every operation count against every highest literal component, and moves the referencing operation and select field from group to group. Unused fields are filled with non-literal selects whose component fields hold large values. A framer that ignored the select would count extra literal words, and one that took only the last operation's references would drop literals. Dedicated cases cover:
- two operations whose references must be combined into a maximum;
- a word held at the input during backpressure, where a dropped or duplicated word would show up as a wrong or repeated lane 0;
- five unterminated operations, where a framer that waited for a sixth word would swallow the next group;
- reset in the middle of a group, where a partial group would leak through as a beat.

// File: rtl/afr_pkg.sv
package afr_pkg;

    localparam int AFR_WORD_W    = 64;
    localparam int AFR_LANES     = 5;
    localparam int AFR_LIT_WORDS = 2;
    localparam int AFR_SRC_N     = 3;
    localparam int AFR_LAST_POS  = 63;
    localparam int AFR_SEL_W     = 2;
    localparam int AFR_IDX_W     = 2;
    localparam int AFR_IDX_BASE  = 8;
    localparam logic [AFR_SEL_W-1:0] AFR_SEL_LIT = 2'b11;

    typedef enum logic [1:0] {
        FR_OPS  = 2'd0,
        FR_LITS = 2'd1,
        FR_HOLD = 2'd2
    } fr_state_e;

    typedef struct packed {
        logic                 hit;
        logic [AFR_IDX_W-1:0] top;
    } lit_ref_t;

    function automatic lit_ref_t merge_ref(input lit_ref_t a, input lit_ref_t b);
        lit_ref_t r;
        if (!a.hit) begin
            r = b;
        end else if (!b.hit) begin
            r = a;
        end else begin
            r.hit = 1'b1;
            r.top = (a.top > b.top) ? a.top : b.top;
        end
        return r;
    endfunction

    function automatic int unsigned words_for_ref(input lit_ref_t r);
        return r.hit ? (int'(r.top) / 2 + 1) : 0;
    endfunction

endpackage

// File: rtl/afr_op_scan.sv
module afr_op_scan
    import afr_pkg::*;
#(
    parameter int WORD_W = AFR_WORD_W,
    parameter int SRC_N  = AFR_SRC_N
) (
    input  logic [WORD_W-1:0] word,
    output lit_ref_t          ref_o
);

    lit_ref_t per_src [SRC_N];

    generate
        for (genvar g = 0; g < SRC_N; g++) begin : g_src
            assign per_src[g] = {
                word[AFR_SEL_W*g +: AFR_SEL_W] == AFR_SEL_LIT,
                word[AFR_IDX_BASE + AFR_IDX_W*g +: AFR_IDX_W]
            };
        end
    endgenerate

    always_comb begin
        lit_ref_t acc;
        acc = '0;
        for (int i = 0; i < SRC_N; i++) begin
            acc = merge_ref(acc, per_src[i]);
        end
        ref_o = acc;
    end

endmodule

// File: rtl/afr_store.sv
module afr_store
    import afr_pkg::*;
#(
    parameter int WORD_W    = AFR_WORD_W,
    parameter int LANES     = AFR_LANES,
    parameter int LIT_WORDS = AFR_LIT_WORDS
) (
    input  logic                                               clk,
    input  logic                                               rst,
    input  logic                                               clear,
    input  logic                                               op_we,
    input  logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0]       op_idx,
    input  logic                                               lit_we,
    input  logic [((LIT_WORDS > 1) ? $clog2(LIT_WORDS) : 1)-1:0] lit_idx,
    input  logic [WORD_W-1:0]                                  din,
    output logic [LANES*WORD_W-1:0]                            ops_flat,
    output logic [LIT_WORDS*WORD_W-1:0]                        lits_flat
);

    localparam int OPI_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int LI_W  = (LIT_WORDS > 1) ? $clog2(LIT_WORDS) : 1;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [WORD_W-1:0] lane_q;
            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    lane_q <= '0;
                end else if (op_we && op_idx == OPI_W'(g)) begin
                    lane_q <= din;
                end
            end
            assign ops_flat[WORD_W*g +: WORD_W] = lane_q;
        end

        for (genvar k = 0; k < LIT_WORDS; k++) begin : g_lit
            logic [WORD_W-1:0] lit_q;
            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    lit_q <= '0;
                end else if (lit_we && lit_idx == LI_W'(k)) begin
                    lit_q <= din;
                end
            end
            assign lits_flat[WORD_W*k +: WORD_W] = lit_q;
        end
    endgenerate

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clear |=> (ops_flat == '0 && lits_flat == '0)); // R9

    AST_NO_WRITE_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear |-> !(op_we || lit_we)); // R7

endmodule

// File: rtl/afr_seq.sv
module afr_seq
    import afr_pkg::*;
#(
    parameter int LANES     = AFR_LANES,
    parameter int LIT_WORDS = AFR_LIT_WORDS
) (
    input  logic                                               clk,
    input  logic                                               rst,
    input  logic                                               in_valid,
    output logic                                               in_ready,
    input  logic                                               op_last,
    input  lit_ref_t                                           ref_in,
    output logic                                               out_valid,
    input  logic                                               out_ready,
    output logic                                               op_we,
    output logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0]       wr_op_idx,
    output logic                                               lit_we,
    output logic [((LIT_WORDS > 1) ? $clog2(LIT_WORDS) : 1)-1:0] wr_lit_idx,
    output logic                                               clear,
    output logic [$clog2(LANES+1)-1:0]                         op_count,
    output logic [$clog2(LIT_WORDS+1)-1:0]                     lit_count,
    output logic                                               err
);

    localparam int OPI_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int LI_W  = (LIT_WORDS > 1) ? $clog2(LIT_WORDS) : 1;
    localparam int OPC_W = $clog2(LANES+1);
    localparam int LCW   = $clog2(LIT_WORDS+1);

    fr_state_e        state;
    logic [OPC_W-1:0] op_cnt;
    logic [LCW-1:0]   lit_got;
    logic [LCW-1:0]   lit_need;
    lit_ref_t         acc_ref;
    logic             err_q;

    lit_ref_t         ref_n;
    logic [LCW-1:0]   need_n;
    logic             take;

    assign in_ready   = (state != FR_HOLD);
    assign out_valid  = (state == FR_HOLD);
    assign take       = in_valid && in_ready;
    assign ref_n      = merge_ref(acc_ref, ref_in);
    assign need_n     = LCW'(words_for_ref(ref_n));
    assign op_we      = take && (state == FR_OPS);
    assign lit_we     = take && (state == FR_LITS);
    assign wr_op_idx  = OPI_W'(op_cnt);
    assign wr_lit_idx = LI_W'(lit_got);
    assign clear      = (state == FR_HOLD) && out_ready;
    assign op_count   = op_cnt;
    assign lit_count  = lit_got;
    assign err        = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= FR_OPS;
            op_cnt   <= '0;
            lit_got  <= '0;
            lit_need <= '0;
            acc_ref  <= '0;
            err_q    <= 1'b0;
        end else begin
            case (state)
                FR_OPS: begin
                    if (take) begin
                        op_cnt  <= op_cnt + OPC_W'(1);
                        acc_ref <= ref_n;
                        if (op_last) begin
                            lit_need <= need_n;
                            state    <= (need_n == '0) ? FR_HOLD : FR_LITS;
                        end else if (op_cnt == OPC_W'(LANES-1)) begin
                            err_q <= 1'b1;
                            state <= FR_HOLD;
                        end
                    end
                end
                FR_LITS: begin
                    if (take) begin
                        lit_got <= lit_got + LCW'(1);
                        if (lit_got + LCW'(1) == lit_need) begin
                            state <= FR_HOLD;
                        end
                    end
                end
                FR_HOLD: begin
                    if (out_ready) begin
                        state    <= FR_OPS;
                        op_cnt   <= '0;
                        lit_got  <= '0;
                        lit_need <= '0;
                        acc_ref  <= '0;
                        err_q    <= 1'b0;
                    end
                end
                default: state <= FR_OPS;
            endcase
        end
    end

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(op_count)
                                       && $stable(lit_count) && $stable(err))); // R6

    AST_OP_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (op_count != '0 && op_count <= OPC_W'(LANES))); // R2

    AST_LIT_MATCHES_REFS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !err) |-> (lit_count == LCW'(words_for_ref(acc_ref)))); // R4

    AST_ERR_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && err) |-> (op_count == OPC_W'(LANES) && lit_count == '0)); // R8

    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (!out_valid && op_count == '0 && !err)); // R7

endmodule

// File: rtl/alu_group_framer.sv
module alu_group_framer
    import afr_pkg::*;
#(
    parameter int WORD_W    = AFR_WORD_W,
    parameter int LANES     = AFR_LANES,
    parameter int LIT_WORDS = AFR_LIT_WORDS
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               in_valid,
    output logic                               in_ready,
    input  logic [WORD_W-1:0]                  in_word,
    output logic                               out_valid,
    input  logic                               out_ready,
    output logic [LANES*WORD_W-1:0]            out_ops,
    output logic [LANES-1:0]                   out_lane_valid,
    output logic [LIT_WORDS*WORD_W-1:0]        out_lits,
    output logic [2*LIT_WORDS-1:0]             out_half_valid,
    output logic [$clog2(LANES+1)-1:0]         out_op_count,
    output logic [$clog2(LIT_WORDS+1)-1:0]     out_lit_count,
    output logic                               out_error
);

    localparam int OPI_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int LI_W   = (LIT_WORDS > 1) ? $clog2(LIT_WORDS) : 1;
    localparam int HALVES = 2 * LIT_WORDS;

    lit_ref_t          scan_ref;
    logic              op_we;
    logic              lit_we;
    logic              clear;
    logic [OPI_W-1:0]  wr_op_idx;
    logic [LI_W-1:0]   wr_lit_idx;

    afr_op_scan #(
        .WORD_W (WORD_W),
        .SRC_N  (AFR_SRC_N)
    ) u_scan (
        .word  (in_word),
        .ref_o (scan_ref)
    );

    afr_seq #(
        .LANES     (LANES),
        .LIT_WORDS (LIT_WORDS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .op_last    (in_word[AFR_LAST_POS]),
        .ref_in     (scan_ref),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .op_we      (op_we),
        .wr_op_idx  (wr_op_idx),
        .lit_we     (lit_we),
        .wr_lit_idx (wr_lit_idx),
        .clear      (clear),
        .op_count   (out_op_count),
        .lit_count  (out_lit_count),
        .err        (out_error)
    );

    afr_store #(
        .WORD_W    (WORD_W),
        .LANES     (LANES),
        .LIT_WORDS (LIT_WORDS)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .op_we     (op_we),
        .op_idx    (wr_op_idx),
        .lit_we    (lit_we),
        .lit_idx   (wr_lit_idx),
        .din       (in_word),
        .ops_flat  (out_ops),
        .lits_flat (out_lits)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane_mask
            assign out_lane_valid[g] = out_valid && (int'(out_op_count) > g);
        end
        for (genvar h = 0; h < HALVES; h++) begin : g_half_mask
            assign out_half_valid[h] = out_valid && (2 * int'(out_lit_count) > h);
        end
    endgenerate

    AST_READY_WHILE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && $past(!rst) && $past(out_valid && out_ready)) |-> in_ready); // R7

    AST_MASK_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_lane_valid) == int'(out_op_count)
                       && out_lane_valid[0])); // R2

endmodule

// File: tb/alu_group_framer_tb.sv
`timescale 1ns/1ps
module alu_group_framer_tb;

    localparam int W  = 64;
    localparam int L  = 5;
    localparam int LW = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [W-1:0]      in_word = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [L*W-1:0]    out_ops;
    logic [L-1:0]      out_lane_valid;
    logic [LW*W-1:0]   out_lits;
    logic [2*LW-1:0]   out_half_valid;
    logic [2:0]        out_op_count;
    logic [1:0]        out_lit_count;
    logic              out_error;

    always #2.5 clk = ~clk;

    alu_group_framer u_dut (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_word        (in_word),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_ops        (out_ops),
        .out_lane_valid (out_lane_valid),
        .out_lits       (out_lits),
        .out_half_valid (out_half_valid),
        .out_op_count   (out_op_count),
        .out_lit_count  (out_lit_count),
        .out_error      (out_error)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int gap     = 0;
    bit done    = 0;

    logic [W-1:0] exp_ops  [L];
    logic [W-1:0] exp_lits [LW];

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_op(int gid, int lane, bit last, int ref_idx, int field, int filler);
        logic [63:0] w;
        w = '0;
        w[63]    = last;
        w[47:16] = 32'(gid * 16 + lane) ^ 32'hA5A5_0000;
        for (int f = 0; f < 3; f++) begin
            w[2*f +: 2]     = 2'((filler + f) % 3);
            w[8 + 2*f +: 2] = 2'(3 - f);
        end
        if (ref_idx >= 0) begin
            w[2*field +: 2]     = 2'b11;
            w[8 + 2*field +: 2] = 2'(ref_idx);
        end
        return w;
    endfunction

    function automatic logic [63:0] mk_lit(int gid, int k);
        return {32'(gid * 4 + 2*k + 1) ^ 32'h3C3C_0000, 32'(gid * 4 + 2*k) ^ 32'hC3C3_0000};
    endfunction

    task automatic push(input logic [63:0] w);
        in_valid = 1'b1;
        in_word  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic check_beat(input int nops, input int nlits, input bit err, input int hold);
        logic [63:0] e;
        chk(out_valid == 1'b1, "R6 out_valid after final word", 64'(out_valid), 64'd1);
        chk(out_op_count == 3'(nops), "R2 op count", 64'(out_op_count), 64'(nops));
        chk(out_lit_count == 2'(nlits), "R4 literal count", 64'(out_lit_count), 64'(nlits));
        chk(out_error == err, "R8 error flag", 64'(out_error), 64'(err));
        for (int i = 0; i < L; i++) begin
            e = (i < nops) ? exp_ops[i] : 64'd0;
            chk(out_ops[W*i +: W] == e, $sformatf("R2/R9 lane %0d", i), out_ops[W*i +: W], e);
            chk(out_lane_valid[i] == (i < nops), $sformatf("R2 lane mask %0d", i),
                64'(out_lane_valid[i]), 64'(i < nops));
        end
        for (int h = 0; h < 2*LW; h++) begin
            e = (h < 2*nlits) ? 64'(h[0] ? exp_lits[h/2][63:32] : exp_lits[h/2][31:0]) : 64'd0;
            chk(64'(out_lits[32*h +: 32]) == e, $sformatf("R5/R9 half %0d", h), 64'(out_lits[32*h +: 32]), e);
            chk(out_half_valid[h] == (h < 2*nlits), $sformatf("R5 half mask %0d", h),
                64'(out_half_valid[h]), 64'(h < 2*nlits));
        end
        for (int c = 0; c < hold; c++) begin
            @(negedge clk);
            chk(out_valid && out_op_count == 3'(nops) && out_lit_count == 2'(nlits),
                "R6 beat held under backpressure", 64'(out_op_count), 64'(nops));
            chk(in_ready == 1'b0, "R7 in_ready low while held", 64'(in_ready), 64'd0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R7 out_valid drops after hand-off", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R7 in_ready back after hand-off", 64'(in_ready), 64'd1);
    endtask

    task automatic send_and_check(input int gid, input int nops, input int nlits, input bit err, input int hold);
        for (int k = 0; k < LW; k++) exp_lits[k] = (k < nlits) ? mk_lit(gid, k) : 64'd0;
        for (int i = 0; i < nops; i++) push(exp_ops[i]);
        for (int k = 0; k < nlits; k++) push(exp_lits[k]);
        if (gap > 0) begin
            // out_valid rose one cycle after the final accept; idle cycles already elapsed
        end
        check_beat(nops, nlits, err, hold);
    endtask

    task automatic run_group(input int gid, input int nops, input int ref_idx, input int ref_lane,
                             input int field, input int hold);
        int rl;
        rl = ref_lane % nops;
        for (int i = 0; i < L; i++) exp_ops[i] = 64'd0;
        for (int i = 0; i < nops; i++) begin
            exp_ops[i] = mk_op(gid, i, i == nops - 1, (i == rl) ? ref_idx : -1, field, gid + i);
        end
        send_and_check(gid, nops, (ref_idx < 0) ? 0 : ref_idx / 2 + 1, 1'b0, hold);
    endtask

    initial begin
        int gid;
        logic [63:0] held;
        gid = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);
        chk(out_op_count == 3'd0, "R1 op count after reset", 64'(out_op_count), 64'd0);

        // R2 R3 R4 R5: sweep of op count against highest literal component
        for (int n = 1; n <= L; n++) begin
            for (int r = -1; r <= 3; r++) begin
                gid++;
                gap = 0;
                run_group(gid, n, r, gid, gid % 3, gid % 3);
            end
        end

        // R3 R4: references in two ops, maximum taken across the group
        gid++;
        gap = 1;
        for (int i = 0; i < L; i++) exp_ops[i] = 64'd0;
        exp_ops[0] = mk_op(gid, 0, 1'b0, 1, 0, 0);
        exp_ops[1] = mk_op(gid, 1, 1'b0, 2, 2, 1);
        exp_ops[2] = mk_op(gid, 2, 1'b1, 0, 1, 2);
        send_and_check(gid, 3, 2, 1'b0, 1);
        gap = 0;

        // R3: non-literal selects with large component fields
        gid++;
        for (int i = 0; i < L; i++) exp_ops[i] = 64'd0;
        exp_ops[0] = mk_op(gid, 0, 1'b1, -1, 0, 1);
        send_and_check(gid, 1, 0, 1'b0, 0);

        // R7: word held at the input during backpressure is taken exactly once
        gid++;
        run_group(gid, 2, 0, 0, 1, -1 + 1);
        gid++;
        for (int i = 0; i < L; i++) exp_ops[i] = 64'd0;
        exp_ops[0] = mk_op(gid, 0, 1'b1, 1, 0, 0);
        push(exp_ops[0]);
        exp_lits[0] = mk_lit(gid, 0);
        held = mk_op(gid + 1, 0, 1'b1, -1, 0, 2);
        push(exp_lits[0]);
        chk(out_valid == 1'b1, "R7 group ready", 64'(out_valid), 64'd1);
        in_valid = 1'b1;
        in_word  = held;
        repeat (3) begin
            @(negedge clk);
            chk(in_ready == 1'b0, "R7 input blocked while held", 64'(in_ready), 64'd0);
        end
        chk(out_ops[63:0] == exp_ops[0], "R7 held beat unchanged", out_ops[63:0], exp_ops[0]);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_op_count == 3'd1, "R7 held word forms next group", 64'(out_op_count), 64'd1);
        chk(out_ops[63:0] == held, "R7 held word on lane 0", out_ops[63:0], held);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        gid += 2;
        run_group(gid, 1, -1, 0, 0, 0);

        // R8: five operations without a terminator
        gid++;
        for (int i = 0; i < L; i++) exp_ops[i] = mk_op(gid, i, 1'b0, (i == 2) ? 3 : -1, 1, i);
        send_and_check(gid, 5, 0, 1'b1, 1);
        gid++;
        run_group(gid, 2, 1, 1, 2, 0);

        // R10: reset in the middle of a group
        gid++;
        push(mk_op(gid, 0, 1'b0, 3, 0, 0));
        push(mk_op(gid, 1, 1'b0, -1, 0, 1));
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 no beat after mid-group reset", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R10 ready after mid-group reset", 64'(in_ready), 64'd1);
        gid++;
        run_group(gid, 1, -1, 0, 0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule